// File: doc/BRIEF.md
# Three-Wire Serial Word Transmitter

This block takes a 16-bit parallel word and sends it out over a three-wire link made of a serial data line, a serial clock and an active-low latch line. The block makes the serial clock itself from the system clock. It pulls the latch low for the whole frame and shifts the word out most significant bit first. After the last bit has been clocked, it raises the latch so that the far-end receiver commits the word. The receiver samples the data line on every rising edge of the serial clock.

Each bit takes two system-clock steps. In the first step the bit is placed on the data line while the serial clock is low. In the second step the serial clock is driven high. After the frame there is one guard cycle with the latch high. The block then returns to idle, so one word costs 34 system-clock cycles from acceptance to the next possible acceptance.

A word can start a frame in one of two ways, chosen by a mode pin:
- **Handshake mode.** The word is taken on a valid/ready handshake, and identical consecutive words are still sent. Back-pressure works as follows: `in_ready` is high only in idle. A word is taken on a rising clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the upstream source must hold its word, and the block ignores `in_word` and `in_valid`.
- **Change-detect mode.** The block sends a frame whenever the input word differs from the last word sent. `in_valid` has no effect in this mode.

Top module: `serial_word_tx`

## Requirements
- R1: After reset, `ser_latch_n` is 1, `ser_clk` is 0, `ser_data` is 0, `in_ready` is 1 and `busy` is 0. The last-sent word register holds 16'h0000, so in change-detect mode an input of 16'h0000 starts no frame.
- R2: Each frame carries exactly 16 bits, most significant bit (bit 15) first. The 16 values captured on the rising edges of `ser_clk` rebuild the accepted word.
- R3: `ser_latch_n` falls on the acceptance edge and stays low until the 32nd edge after it, where it rises with `ser_clk` low. `ser_clk` is never high while `ser_latch_n` is high.
- R4: Each bit takes two cycles. Bit k (k = 0 for bit 15) is on `ser_data` with `ser_clk` low after edge 2k and with `ser_clk` high after edge 2k+1. `ser_data` never changes on an edge where `ser_clk` rises.
- R5: When `chg_mode` is 0 (handshake), a word is accepted when `in_valid` and `in_ready` are both high at an edge. An identical consecutive word is sent again.
- R6: `in_ready` is low from the acceptance edge until the 33rd edge after it, and `busy` is always the inverse of `in_ready`. A change on `in_word` while `in_ready` is low does not alter the frame in flight.
- R7: When `chg_mode` is 1 (change-detect), a frame starts at an idle edge if and only if `in_word` differs from the last word sent. `in_valid` is ignored.
- R8: Two acceptances are at least 34 cycles apart. With a word held valid, the next frame is accepted exactly 34 edges after the previous one.
- R9: `ser_data` returns to 0 on the edge where `ser_latch_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_mode | input | 1 | 1: change-detect start, 0: valid/ready handshake start |
| in_word | input | 16 | Parallel word to send |
| in_valid | input | 1 | Word valid (handshake mode only) |
| in_ready | output | 1 | High when idle and able to take a word |
| busy | output | 1 | High while a frame or its guard cycle is in progress |
| ser_data | output | 1 | Serial data line, MSB first |
| ser_clk | output | 1 | Generated serial clock; the receiver samples on its rising edge |
| ser_latch_n | output | 1 | Active-low latch/select; its rising edge commits the word |

## Verification
Two events can fall on the same edge:
- **Frame end and next acceptance.** The end of one frame and the acceptance of the next meet when `in_valid` is held high across a frame. The bench drives this case and checks, cycle by cycle, the 34-cycle spacing, the guard cycle and the latch falling again exactly on edge 34.
- **Frame in flight and new word.** A new word is presented while a frame is in flight. The bench changes `in_word` right after acceptance, with `in_valid` still held, and checks two things: the receiver rebuilds the original word, and the new word leaves only as the following frame.

// File: rtl/swt_pkg.sv
package swt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CLKHI = 2'd2,
    ST_GUARD = 2'd3
  } tx_state_t;
endpackage

// File: rtl/swt_trigger.sv
module swt_trigger #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_mode,
  input  logic [WORD_W-1:0] word,
  input  logic              valid,
  input  logic              idle,
  output logic              start
);
  logic [WORD_W-1:0] last_sent_q;
  logic              differs;

  assign differs = (word != last_sent_q);

  always_comb begin
    if (!idle)          start = 1'b0;
    else if (chg_mode)  start = differs;
    else                start = valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last_sent_q <= '0;
    else if (start) last_sent_q <= word;
  end

  // R6
  start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !idle) else $error("start did not leave idle");
endmodule

// File: rtl/swt_shifter.sv
module swt_shifter #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              clear,
  input  logic [WORD_W-1:0] word,
  output logic              msb,
  output logic              last_bit
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q;
  logic [CNT_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hold_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      hold_q <= word;
      idx_q  <= '0;
    end else if (advance) begin
      hold_q <= {hold_q[WORD_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign msb      = hold_q[WORD_W-1];
  assign last_bit = (idx_q == LAST_IDX);

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !last_bit) else $error("shift past last bit");
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_mode,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              busy,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_latch_n
);
  import swt_pkg::*;

  localparam int FRAME_CYC = 2 * WORD_W + 2;
  localparam int GAP_W     = $clog2(FRAME_CYC + 1);
  localparam int RISE_W    = $clog2(WORD_W + 1);

  tx_state_t state_q;
  logic      sclk_q;
  logic      latch_q;
  logic      start;
  logic      last_bit;
  logic      load, advance, clear;
  logic      idle;

  assign idle    = (state_q == ST_IDLE);
  assign load    = start;
  assign advance = (state_q == ST_CLKHI) && !last_bit;
  assign clear   = (state_q == ST_CLKHI) && last_bit;

  swt_trigger #(.WORD_W(WORD_W)) u_trigger (
    .clk      (clk),
    .rst_n    (rst_n),
    .chg_mode (chg_mode),
    .word     (in_word),
    .valid    (in_valid),
    .idle     (idle),
    .start    (start)
  );

  swt_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .advance  (advance),
    .clear    (clear),
    .word     (in_word),
    .msb      (ser_data),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      latch_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= 1'b0;
          if (start) begin
            latch_q <= 1'b0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          sclk_q  <= 1'b1;
          state_q <= ST_CLKHI;
        end
        ST_CLKHI: begin
          sclk_q <= 1'b0;
          if (last_bit) begin
            latch_q <= 1'b1;
            state_q <= ST_GUARD;
          end else begin
            state_q <= ST_SETUP;
          end
        end
        ST_GUARD: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk     = sclk_q;
  assign ser_latch_n = latch_q;
  assign in_ready    = idle;
  assign busy        = !idle;

  // checker state: cycles since last start, clock rises in this frame
  logic [GAP_W-1:0]  since_q;
  logic [RISE_W-1:0] rises_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= GAP_W'(FRAME_CYC);
      rises_q <= '0;
    end else begin
      if (start)                                since_q <= GAP_W'(1);
      else if (since_q < GAP_W'(FRAME_CYC))     since_q <= since_q + 1'b1;
      if (start)                                rises_q <= '0;
      else if ($rose(ser_clk))                  rises_q <= rises_q + 1'b1;
    end
  end

  // R3
  clk_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !ser_latch_n) else $error("serial clock high with latch high");

  // R4
  data_steady_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data)) else $error("data moved with clock rise");

  // R8
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (since_q >= GAP_W'(FRAME_CYC))) else $error("frames too close");

  // R2
  sixteen_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_latch_n) |-> (rises_q == RISE_W'(WORD_W))) else $error("wrong bit count");

  // R9
  data_low_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_latch_n) |-> !ser_data) else $error("data not low at latch rise");

  // R6
  busy_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_latch_n) |-> busy && !in_ready) else $error("ready high during frame");
endmodule

// File: tb/serial_word_tx_bench.sv
module serial_word_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chg_mode = 1'b0;
  logic [15:0] in_word = 16'h0000;
  logic        in_valid = 1'b0;
  logic        in_ready, busy, ser_data, ser_clk, ser_latch_n;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  serial_word_tx u_serial_word_tx (
    .clk(clk), .rst_n(rst_n), .chg_mode(chg_mode), .in_word(in_word),
    .in_valid(in_valid), .in_ready(in_ready), .busy(busy),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch_n(ser_latch_n)
  );

  // receiver model
  logic [15:0] shift_cap = '0;
  logic [15:0] last_cap = '0;
  int          nbits = 0;
  int          last_bits = 0;
  int          frames = 0;
  int          stray_rises = 0;

  always @(posedge ser_clk) if (rst_n === 1'b1) begin
    shift_cap = {shift_cap[14:0], ser_data};
    nbits++;
    if (ser_latch_n !== 1'b0) stray_rises++;
  end

  always @(posedge ser_latch_n) if (rst_n === 1'b1) begin
    last_cap  = shift_cap;
    last_bits = nbits;
    nbits     = 0;
    frames++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (in_ready === 1'b1) break;
    end
  endtask

  // {chg_mode, expect_frame, word}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h0900},
    {1'b0, 1'b1, 16'h0900},
    {1'b0, 1'b1, 16'hA5C3},
    {1'b1, 1'b0, 16'hA5C3},
    {1'b1, 1'b1, 16'h0C01},
    {1'b1, 1'b0, 16'h0C01},
    {1'b1, 1'b1, 16'hFFFF},
    {1'b0, 1'b1, 16'h0000},
    {1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b1, 16'h8001}
  };

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int f0;
    int bad_latch, bad_clk, bad_rdy, bad_data;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 latch", ser_latch_n, 1);
    chk("R1 sclk", ser_clk, 0);
    chk("R1 data", ser_data, 0);
    chk("R1 ready", in_ready, 1);
    chk("R1 busy", busy, 0);

    // R1/R7: change mode, word equal to reset last-sent 0000, valid ignored
    chg_mode = 1'b1; in_word = 16'h0000; in_valid = 1'b1;
    f0 = frames;
    repeat (40) @(negedge clk);
    chk("R1 R7 no frame for 0000", frames - f0, 0);
    in_valid = 1'b0;

    // table walk: R2 R5 R7
    for (int i = 0; i < NV; i++) begin
      wait_idle();
      f0 = frames;
      chg_mode = VEC[i][17];
      in_word  = VEC[i][15:0];
      in_valid = !VEC[i][17];
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (40) @(negedge clk);
      chk(VEC[i][17] ? "R7 frame count" : "R5 frame count", frames - f0, 32'(VEC[i][16]));
      if (VEC[i][16]) begin
        chk("R2 captured word", last_cap, VEC[i][15:0]);
        chk("R2 bit count", last_bits, 16);
      end
    end

    // R3 R4 R6 R8 R9: cycle-by-cycle frame with valid held across the boundary
    wait_idle();
    f0 = frames;
    chg_mode = 1'b0; in_word = 16'h1234; in_valid = 1'b1;
    @(posedge clk);
    bad_latch = 0; bad_clk = 0; bad_rdy = 0; bad_data = 0;
    for (int i = 1; i <= 35; i++) begin
      int j;
      logic e_latch, e_clk, e_rdy, e_data;
      @(negedge clk);
      j = i - 1;
      e_latch = !(j < 32 || j == 34);
      e_clk   = (j < 32) && (j % 2 == 1);
      e_rdy   = (j == 33);
      e_data  = (j < 32) ? in_word[15 - j/2] : ((j == 34) ? in_word[15] : 1'b0);
      if (ser_latch_n !== e_latch) bad_latch++;
      if (ser_clk !== e_clk) bad_clk++;
      if (in_ready !== e_rdy || busy !== !e_rdy) bad_rdy++;
      if (ser_data !== e_data) bad_data++;
    end
    in_valid = 1'b0;
    chk("R3 R8 latch timing", bad_latch, 0);
    chk("R4 clock timing", bad_clk, 0);
    chk("R6 ready/busy timing", bad_rdy, 0);
    chk("R4 R9 data timing", bad_data, 0);
    repeat (40) @(negedge clk);
    chk("R8 back-to-back frames", frames - f0, 2);
    chk("R3 no clock outside frame", stray_rises, 0);

    // R6: word change while busy is ignored, then sent as next frame
    wait_idle();
    f0 = frames;
    in_word = 16'h5A5A; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_word = 16'hFFFF;
    wait_idle();
    chk("R6 in-flight word kept", last_cap, 16'h5A5A);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R6 held word sent next", last_cap, 16'hFFFF);
    chk("R6 frame count", frames - f0, 2);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule